// File: doc/BRIEF.md
# Line Change Timestamp Engine

This block watches a bank of input lines and records the moment any of them changes. The lines are split into groups of 32 called slices. A line's global number is its slice number times 32 plus its bit position inside the slice. Each slice has its own enable mask. On every clock the engine compares each enabled line with the value it sampled on the previous clock. For each slice where at least one enabled line differs, it pushes one record into a FIFO. The record holds the value of a free-running 64-bit tick counter, the slice number, and the slice's previous and current 32-bit values. Software XORs the two values to find which lines moved.

Software talks to the block through a flat 32-bit register bus. Reads are combinational and have no side effects. The read ports always show the record at the head of the FIFO. Software drains the FIFO by reading the head and then writing the pop command, and repeats while the occupancy field in the status register is nonzero. An interrupt level output tells software when the occupancy has reached a programmable threshold.

Top module: `edge_stamp_top`

## Requirements
- R1: After reset:
  - the FIFO is empty and irqOut is low;
  - the control, status and all slice enable registers read 0.
- R2: With the engine on, any change on an enabled line of a slice pushes exactly one record for that slice. The occupancy in status bits 15:8 shows the new count on the clock after the change.
- R3: In a record:
  - the current value is the slice's full 32-bit input;
  - current XOR previous has a 1 exactly on the enabled lines that changed;
  - source register bits 23:16 hold the slice number.
- R4: A change on a line whose enable bit is 0 pushes nothing.
- R5: With control bit 0 cleared, no record is pushed. The slice enable registers keep their values and still read back.
- R6: When several slices change on the same clock, each gets its own record. Pop order is lowest slice number first.
- R7: Writing a value with bit 0 set to the command register (0x1C) removes the head record. A pop while the FIFO is empty has no effect.
- R8: The 64-bit tick counter advances by one every clock. A record holds the counter value of the clock that detected the change; high word at 0x04, low word at 0x08. Records from changes G clocks apart differ by exactly G.
- R9: When the FIFO is full, new records are dropped and status bit 0 becomes a sticky overflow flag. Writing 1 to status bit 0 clears the flag and leaves the stored records untouched. The occupancy never exceeds FIFO_DEPTH, which must be a power of two no larger than 128.
- R10: irqOut is high exactly when control bit 1 is set and the occupancy is at least the threshold in control bits 15:8. A threshold of 0 acts as 1.
- R11: Register map:

  | Offset | Register |
  | --- | --- |
  | 0x00 | control |
  | 0x04 / 0x08 | timestamp high / low |
  | 0x0C | source |
  | 0x10 | current value |
  | 0x14 | previous value |
  | 0x1C | command |
  | 0x20 | status |
  | 0x40 + 0x20·s | enable for slice s |

  Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | NUM_SLICES*32 | Watched lines, already synchronised; bit 32*s+n is line n of slice s |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrEn | input | 1 | Write strobe, one clock per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| irqOut | output | 1 | Level interrupt on occupancy threshold |

## Verification
The bench runs with two slices and a four-entry FIFO. It sweeps every bit position of a slice under a mixed enable mask; a design that ignored the mask would report changes on disabled lines. Several lines are toggled together, and two slices are toggled on the same clock. This catches a design that splits one slice into several records, or that loses or reorders the second slice. Timestamp gaps are compared with the clock count, which exposes an off-by-one latch point. The FIFO is then overfilled, cleared and drained, and a pop is issued while empty; a wrongly decremented pointer would corrupt the following records. The interrupt is swept across its enable, a threshold of two and a threshold of zero, and the engine is switched off to confirm the enable masks are kept.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;
  localparam int LINES_PER_SLICE = 32;
  localparam int TS_W = 64;

  // byte offsets on the register bus
  localparam int OFS_CTRL    = 'h00;
  localparam int OFS_TS_HI   = 'h04;
  localparam int OFS_TS_LO   = 'h08;
  localparam int OFS_SOURCE  = 'h0C;
  localparam int OFS_CURVAL  = 'h10;
  localparam int OFS_PREVVAL = 'h14;
  localparam int OFS_CMD     = 'h1C;
  localparam int OFS_STATUS  = 'h20;
  localparam int SLICE_EN_BASE   = 'h40;
  localparam int SLICE_EN_STRIDE = 'h20;

  // control -> datapath strobes
  typedef struct packed {
    logic engineOn;
    logic popReq;
    logic ovfClear;
  } dpStrobe_t;

  typedef struct packed {
    logic [TS_W-1:0] stamp;
    logic [7:0]      slice;
    logic [31:0]     prevVal;
    logic [31:0]     curVal;
  } stampEntry_t;
endpackage

// File: rtl/edge_stamp_dp.sv
module edge_stamp_dp import edge_stamp_pkg::*; #(
  parameter  int NUM_SLICES = 3,
  parameter  int FIFO_DEPTH = 32,
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1),
  localparam int PTR_W  = $clog2(FIFO_DEPTH),
  localparam int LINE_W = NUM_SLICES * LINES_PER_SLICE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] lineIn,
  input  logic [LINE_W-1:0] sliceEn,
  input  dpStrobe_t         strobe,
  output stampEntry_t       headEntry,
  output logic [CNT_W-1:0]  fillLevel,
  output logic              overflowFlag
);
  logic [LINE_W-1:0]     sampleQ;
  logic [TS_W-1:0]       tsCount;
  logic [PTR_W-1:0]      wrPtr, rdPtr;
  stampEntry_t           fifoMem [FIFO_DEPTH];
  stampEntry_t           newEntry [NUM_SLICES];
  logic [NUM_SLICES-1:0] sliceHit, wrOk;
  logic [PTR_W-1:0]      wrIdx [NUM_SLICES];
  logic [CNT_W-1:0]      freeSlots, acceptCnt;
  logic                  dropAny, doPop;

  // per-slice change detection and record build
  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    logic [31:0] curV, diffV;
    assign curV        = lineIn[s*LINES_PER_SLICE +: LINES_PER_SLICE];
    assign diffV       = (curV ^ sampleQ[s*LINES_PER_SLICE +: LINES_PER_SLICE])
                       & sliceEn[s*LINES_PER_SLICE +: LINES_PER_SLICE];
    assign sliceHit[s] = strobe.engineOn && (diffV != '0);
    assign newEntry[s] = '{stamp: tsCount, slice: 8'(s),
                           prevVal: curV ^ diffV, curVal: curV};
  end

  // slot allocation: lower slice numbers take the earlier slots
  always_comb begin
    freeSlots = CNT_W'(FIFO_DEPTH) - fillLevel;
    acceptCnt = '0;
    dropAny   = 1'b0;
    for (int s = 0; s < NUM_SLICES; s++) begin
      wrOk[s]  = 1'b0;
      wrIdx[s] = wrPtr + PTR_W'(acceptCnt);
      if (sliceHit[s]) begin
        if (acceptCnt < freeSlots) begin
          wrOk[s]   = 1'b1;
          acceptCnt = acceptCnt + CNT_W'(1);
        end else begin
          dropAny = 1'b1;
        end
      end
    end
  end

  assign doPop = strobe.popReq && (fillLevel != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleQ      <= '0;
      tsCount      <= '0;
      wrPtr        <= '0;
      rdPtr        <= '0;
      fillLevel    <= '0;
      overflowFlag <= 1'b0;
    end else begin
      sampleQ   <= lineIn;
      tsCount   <= tsCount + 64'd1;
      wrPtr     <= wrPtr + PTR_W'(acceptCnt);
      rdPtr     <= rdPtr + PTR_W'(doPop);
      fillLevel <= fillLevel + acceptCnt - CNT_W'(doPop);
      if (dropAny)              overflowFlag <= 1'b1;
      else if (strobe.ovfClear) overflowFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_SLICES; s++)
      if (wrOk[s]) fifoMem[wrIdx[s]] <= newEntry[s];
  end

  assign headEntry = fifoMem[rdPtr];
endmodule

// File: rtl/edge_stamp_ctrl.sv
module edge_stamp_ctrl import edge_stamp_pkg::*; #(
  parameter  int NUM_SLICES = 3,
  parameter  int ADDR_W     = 8,
  parameter  int CNT_W      = 6,
  localparam int LINE_W     = NUM_SLICES * LINES_PER_SLICE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  input  stampEntry_t       headEntry,
  input  logic [CNT_W-1:0]  fillLevel,
  input  logic              overflowFlag,
  output logic [31:0]       regRdData,
  output dpStrobe_t         strobe,
  output logic [LINE_W-1:0] sliceEn,
  output logic              irqOut
);
  logic       engineOn, irqEnable;
  logic [7:0] threshold, effThr, fillWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engineOn  <= 1'b0;
      irqEnable <= 1'b0;
      threshold <= '0;
    end else if (regWrEn && regAddr == ADDR_W'(OFS_CTRL)) begin
      engineOn  <= regWrData[0];
      irqEnable <= regWrData[1];
      threshold <= regWrData[15:8];
    end
  end

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_en
    localparam int EN_ADDR = SLICE_EN_BASE + s * SLICE_EN_STRIDE;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        sliceEn[s*LINES_PER_SLICE +: LINES_PER_SLICE] <= '0;
      else if (regWrEn && regAddr == ADDR_W'(EN_ADDR))
        sliceEn[s*LINES_PER_SLICE +: LINES_PER_SLICE] <= regWrData;
    end
  end

  assign strobe = '{
    engineOn: engineOn,
    popReq:   regWrEn && regAddr == ADDR_W'(OFS_CMD) && regWrData[0],
    ovfClear: regWrEn && regAddr == ADDR_W'(OFS_STATUS) && regWrData[0]
  };

  assign effThr   = (threshold == 8'd0) ? 8'd1 : threshold;
  assign fillWide = 8'(fillLevel);
  assign irqOut   = irqEnable && (fillWide >= effThr);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(OFS_CTRL):    regRdData = {16'b0, threshold, 6'b0, irqEnable, engineOn};
      ADDR_W'(OFS_TS_HI):   regRdData = headEntry.stamp[63:32];
      ADDR_W'(OFS_TS_LO):   regRdData = headEntry.stamp[31:0];
      ADDR_W'(OFS_SOURCE):  regRdData = {8'b0, headEntry.slice, 16'b0};
      ADDR_W'(OFS_CURVAL):  regRdData = headEntry.curVal;
      ADDR_W'(OFS_PREVVAL): regRdData = headEntry.prevVal;
      ADDR_W'(OFS_STATUS):  regRdData = {16'b0, fillWide, 7'b0, overflowFlag};
      default:              regRdData = '0;
    endcase
    for (int s = 0; s < NUM_SLICES; s++)
      if (regAddr == ADDR_W'(SLICE_EN_BASE + s * SLICE_EN_STRIDE))
        regRdData = sliceEn[s*LINES_PER_SLICE +: LINES_PER_SLICE];
  end
endmodule

// File: rtl/edge_stamp_top.sv
module edge_stamp_top import edge_stamp_pkg::*; #(
  parameter int NUM_SLICES = 3,
  parameter int FIFO_DEPTH = 32,
  parameter int ADDR_W     = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NUM_SLICES*LINES_PER_SLICE-1:0] lineIn,
  input  logic [ADDR_W-1:0]                     regAddr,
  input  logic                                  regWrEn,
  input  logic [31:0]                           regWrData,
  output logic [31:0]                           regRdData,
  output logic                                  irqOut
);
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int LINE_W = NUM_SLICES * LINES_PER_SLICE;

  dpStrobe_t         dpStrobe;
  stampEntry_t       headEntry;
  logic [CNT_W-1:0]  fillLevel;
  logic              overflowFlag;
  logic [LINE_W-1:0] sliceEn;

  edge_stamp_ctrl #(.NUM_SLICES(NUM_SLICES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .headEntry(headEntry), .fillLevel(fillLevel),
    .overflowFlag(overflowFlag), .regRdData(regRdData), .strobe(dpStrobe),
    .sliceEn(sliceEn), .irqOut(irqOut)
  );

  edge_stamp_dp #(.NUM_SLICES(NUM_SLICES), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .sliceEn(sliceEn),
    .strobe(dpStrobe), .headEntry(headEntry), .fillLevel(fillLevel),
    .overflowFlag(overflowFlag)
  );
endmodule

// File: rtl/edge_stamp_checker.sv
module edge_stamp_checker import edge_stamp_pkg::*; #(
  parameter int NUM_SLICES = 3,
  parameter int FIFO_DEPTH = 32,
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [31:0]       regWrData,
  input logic              irqOut,
  input logic [CNT_W-1:0]  fillLevel,
  input logic              overflowFlag,
  input logic              engineOn
);
  logic ovfClrWrite;
  assign ovfClrWrite = regWrEn && regAddr == ADDR_W'(OFS_STATUS) && regWrData[0];

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    int'(fillLevel) <= FIFO_DEPTH);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag && !ovfClrWrite |=> overflowFlag);

  p_push_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    int'(fillLevel) <= int'($past(fillLevel)) + NUM_SLICES);

  p_pop_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    int'(fillLevel) >= int'($past(fillLevel)) - 1);

  p_engine_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    !engineOn |=> int'(fillLevel) <= int'($past(fillLevel)));

  p_irq_nonempty_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> fillLevel != '0);
endmodule

bind edge_stamp_top edge_stamp_checker #(
  .NUM_SLICES(NUM_SLICES), .FIFO_DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_checker (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .irqOut(irqOut), .fillLevel(fillLevel),
  .overflowFlag(overflowFlag), .engineOn(dpStrobe.engineOn)
);

// File: tb/edge_stamp_top_bench.sv
`timescale 1ns/1ps
module edge_stamp_top_bench;
  localparam int NS = 2;
  localparam int DEPTH = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS*32-1:0] lineIn = '0;
  logic [AW-1:0] regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic          irqOut;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  edge_stamp_top #(.NUM_SLICES(NS), .FIFO_DEPTH(DEPTH), .ADDR_W(AW)) u_edge_stamp_top (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic chkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setLines(input logic [NS*32-1:0] v);
    @(negedge clk);
    lineIn = v;
  endtask

  task automatic countIs(input string tag, input int exp);
    logic [31:0] st;
    rdReg(8'h20, st);
    chkEq(tag, 64'(st[15:8]), 64'(exp));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, cur, prv, ts1, ts2;
    logic [31:0] mask;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdReg(8'h00, rd); chkEq("R1 ctrl", 64'(rd), 0);
    rdReg(8'h20, rd); chkEq("R1 status", 64'(rd), 0);
    rdReg(8'h40, rd); chkEq("R1 slice0 en", 64'(rd), 0);
    rdReg(8'h60, rd); chkEq("R1 slice1 en", 64'(rd), 0);
    chkEq("R1 irq", 64'(irqOut), 0);
    // R11 unmapped address
    rdReg(8'h18, rd); chkEq("R11 unmapped", 64'(rd), 0);

    // R2 R3 R4 sweep every bit under a mixed mask
    mask = 32'h0F0F_3C5A;
    wrReg(8'h40, mask);
    wrReg(8'h00, 32'h1);
    rdReg(8'h40, rd); chkEq("R11 slice0 en readback", 64'(rd), 64'(mask));
    for (int b = 0; b < 32; b++) begin
      setLines(lineIn ^ (64'd1 << b));
      if (mask[b]) begin
        countIs("R2 one record", 1);
        rdReg(8'h0C, rd);  chkEq("R3 source slice", 64'(rd[23:16]), 0);
        rdReg(8'h10, cur); chkEq("R3 current", 64'(cur), 64'(lineIn[31:0]));
        rdReg(8'h14, prv); chkEq("R3 changed lines", 64'(cur ^ prv), 64'(32'd1 << b));
        wrReg(8'h1C, 32'h1);
        countIs("R7 pop empties", 0);
      end else begin
        countIs("R4 masked line", 0);
      end
    end

    // R3 several lines of one slice, with a masked line also moving
    wrReg(8'h40, 32'hFFFF_FFF0);
    setLines(lineIn ^ 64'h0000_0000_8001_0013);
    countIs("R3 single record", 1);
    rdReg(8'h10, cur); rdReg(8'h14, prv);
    chkEq("R3 multi xor", 64'(cur ^ prv), 64'h8001_0010);
    wrReg(8'h1C, 32'h1);

    // R6 R8 two slices on one clock
    wrReg(8'h40, 32'hFFFF_FFFF);
    wrReg(8'h60, 32'hFFFF_FFFF);
    setLines(lineIn ^ 64'h0000_0400_0000_0002);
    countIs("R6 two records", 2);
    rdReg(8'h0C, rd);  chkEq("R6 first slice 0", 64'(rd[23:16]), 0);
    rdReg(8'h08, ts1);
    wrReg(8'h1C, 32'h1);
    rdReg(8'h0C, rd);  chkEq("R6 second slice 1", 64'(rd[23:16]), 1);
    rdReg(8'h10, cur); rdReg(8'h14, prv);
    chkEq("R6 slice1 xor", 64'(cur ^ prv), 64'h0000_0400);
    rdReg(8'h08, ts2); chkEq("R8 same-clock stamps", 64'(ts2), 64'(ts1));
    wrReg(8'h1C, 32'h1);

    // R8 gap of 7 clocks
    setLines(lineIn ^ 64'h1);
    repeat (6) @(negedge clk);
    setLines(lineIn ^ 64'h1);
    countIs("R8 two records", 2);
    rdReg(8'h08, ts1); rdReg(8'h04, rd);
    chkEq("R8 high word", 64'(rd), 0);
    wrReg(8'h1C, 32'h1);
    rdReg(8'h08, ts2);
    chkEq("R8 gap", 64'(ts2 - ts1), 7);
    wrReg(8'h1C, 32'h1);

    // R7 pop while empty is ignored
    wrReg(8'h1C, 32'h1);
    countIs("R7 empty pop", 0);
    setLines(lineIn ^ 64'h4);
    countIs("R7 after empty pop", 1);
    rdReg(8'h10, cur); chkEq("R7 head intact", 64'(cur), 64'(lineIn[31:0]));
    wrReg(8'h1C, 32'h1);

    // R9 overflow
    lineIn[0] = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 5; k++) setLines(lineIn ^ 64'h1);
    rdReg(8'h20, rd);
    chkEq("R9 full count", 64'(rd[15:8]), 4);
    chkEq("R9 overflow set", 64'(rd[0]), 1);
    rdReg(8'h10, cur); chkEq("R9 oldest kept", 64'(cur[0]), 1);
    wrReg(8'h20, 32'h1);
    rdReg(8'h20, rd);
    chkEq("R9 overflow cleared", 64'(rd[0]), 0);
    chkEq("R9 records kept", 64'(rd[15:8]), 4);
    for (int k = 0; k < 4; k++) wrReg(8'h1C, 32'h1);
    countIs("R9 drained", 0);

    // R10 interrupt threshold 2
    wrReg(8'h00, 32'h0000_0203);
    setLines(lineIn ^ 64'h1);
    @(negedge clk); #1 chkEq("R10 below threshold", 64'(irqOut), 0);
    setLines(lineIn ^ 64'h1);
    @(negedge clk); #1 chkEq("R10 at threshold", 64'(irqOut), 1);
    wrReg(8'h1C, 32'h1);
    #1 chkEq("R10 dropped below", 64'(irqOut), 0);
    wrReg(8'h00, 32'h0000_0003);
    #1 chkEq("R10 zero threshold", 64'(irqOut), 1);
    wrReg(8'h00, 32'h0000_0001);
    #1 chkEq("R10 irq disabled", 64'(irqOut), 0);
    wrReg(8'h1C, 32'h1);
    wrReg(8'h00, 32'h0000_0003);
    #1 chkEq("R10 empty no irq", 64'(irqOut), 0);

    // R5 engine off
    wrReg(8'h00, 32'h0);
    setLines(lineIn ^ 64'h0000_0001_0000_0001);
    countIs("R5 no record when off", 0);
    rdReg(8'h40, rd); chkEq("R5 slice0 en kept", 64'(rd), 64'hFFFF_FFFF);
    rdReg(8'h60, rd); chkEq("R5 slice1 en kept", 64'(rd), 64'hFFFF_FFFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule